// File: doc/BRIEF.md
# Pulse Period and Active-Time Meter

This block measures one digital input with a single prescaled up-counter. The input is first brought into the clock domain by a short synchronizer chain. It then passes through a sampled glitch filter. The filter changes its output only after a run of identical samples that disagree with the current level.

Each edge of the filtered signal belongs to one of two roles.

- **Leading edge.** The polarity input chooses it. It copies the running count into the period register, restarts the counter and the prescaler from zero, and emits a capture strobe.
- **Trailing edge.** This is the other edge. It copies the running count into the active-time register and leaves the counter running.

If no leading edge arrives before the counter rolls over, a wrap strobe fires and the result is marked stale. A restart never produces a wrap strobe, so the wrap strobe works as a missing-signal timeout.

The valid flag qualifies the period register. It rises only on a leading edge that has a full measured period behind it, and only if the captured count is non-zero. Software or downstream logic converts the raw counts into frequency and duty cycle. That conversion is not part of this block.

Top module: `pwcap_top`

## Requirements
- R1: The counter advances by one each time the prescaler completes `presc_div`+1 clocks. For leading edges of the filtered input spaced P clocks apart, the captured period is floor((P-1)/(`presc_div`+1)).
- R2: A leading edge loads the running count into `period_o`, restarts counter and prescaler at zero, and pulses `cap_stb_o` for exactly one clock. `period_o` changes at no other time.
- R3: A trailing edge arriving A clocks after the leading edge loads floor((A-1)/(`presc_div`+1)) into `width_o` without restarting the counter.
- R4: With `pol_high`=1 the rising edge is the leading edge and the falling edge is the trailing edge. With `pol_high`=0 the two roles are swapped.
- R5: The filter samples once every FILT_DIV clocks. It takes a new level only after FILT_LEN consecutive samples of that level. An excursion spanning fewer samples produces no capture.
- R6: `ovf_stb_o` pulses for one clock only when a prescaler tick takes the counter from its all-ones value back to zero. That happens 2^CNT_W·(`presc_div`+1) clocks after the last restart. A restart never raises it, and it never coincides with `cap_stb_o`.
- R7: A wrap clears `valid_o`. After a wrap, the next leading edge leaves `valid_o` low.
- R8: `valid_o` stays low on the first leading edge after reset or after a wrap. On each later leading edge it is set to 1 exactly when the captured period is non-zero.
- R9: A synchronous active-high `rst` clears `period_o`, `width_o`, `valid_o`, `cap_stb_o`, `ovf_stb_o`, the counter, the prescaler and the filter state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pol_high | input | 1 | 1: rising edge is the leading edge; 0: falling edge is |
| presc_div | input | PRE_W | Prescaler divide minus one |
| sig_in | input | 1 | Asynchronous measured input |
| period_o | output | CNT_W | Last captured period count |
| width_o | output | CNT_W | Last captured active-time count |
| valid_o | output | 1 | Period register holds a trustworthy measurement |
| cap_stb_o | output | 1 | One-clock strobe after each leading edge |
| ovf_stb_o | output | 1 | One-clock strobe on counter rollover |

## Verification
The assertions assume three things about the inputs:

- `pol_high` and `presc_div` are held steady between resets.
- Every level on `sig_in` lasts long enough for the filter to settle, unless it is meant as a glitch.
- Edges of the filtered signal therefore alternate and never share a clock with each other.

The stimulus changes configuration only while `rst` is held. It places every input transition on a multiple of the filter sample interval, so the filtered edge spacing equals the applied spacing exactly. Glitches are made deliberately one sample shorter than the filter run, and accepted pulses are exactly as long as the run or longer. Leading-edge spacing is always well below the wrap span, except in the two tests that idle on purpose to cause a timeout.

// File: rtl/pwcap_pkg.sv
package pwcap_pkg;

  // role of a filtered transition in the current polarity
  typedef enum logic [1:0] {
    EV_NONE     = 2'd0,
    EV_LEADING  = 2'd1,
    EV_TRAILING = 2'd2
  } pw_event_e;

  function automatic pw_event_e classify(input logic rise, input logic fall,
                                         input logic pol_high);
    if ((rise && pol_high) || (fall && !pol_high)) return EV_LEADING;
    if ((fall && pol_high) || (rise && !pol_high)) return EV_TRAILING;
    return EV_NONE;
  endfunction

endpackage

// File: rtl/pwcap_sync.sv
module pwcap_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= d_i;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (rst) chain_q <= '0;
        else     chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pwcap_filter.sv
module pwcap_filter #(
  parameter int FILT_DIV = 32,
  parameter int FILT_LEN = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  localparam int DW = (FILT_DIV > 1) ? $clog2(FILT_DIV) : 1;
  localparam int RW = $clog2(FILT_LEN + 1);
  localparam logic [DW-1:0] DIV_LAST = DW'(FILT_DIV - 1);
  localparam logic [RW-1:0] RUN_LAST = RW'(FILT_LEN - 1);

  logic [DW-1:0] div_q;
  logic [RW-1:0] run_q;
  logic          lvl_q;
  logic          samp_en;

  assign samp_en = (div_q == DIV_LAST);

  always_ff @(posedge clk) begin
    if (rst || samp_en) div_q <= '0;
    else                div_q <= div_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= '0;
      lvl_q <= 1'b0;
    end else if (samp_en) begin
      if (d_i == lvl_q) begin
        run_q <= '0;
      end else if (run_q == RUN_LAST) begin
        lvl_q <= d_i;
        run_q <= '0;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  assign q_o = lvl_q;

  // R5: the filtered level moves only on a sample that ends a full run
  p_filt_on_sample_r5: assert property (@(posedge clk) disable iff (rst)
    (lvl_q != $past(lvl_q)) |-> ($past(samp_en) && ($past(run_q) == RUN_LAST)));

  // R5: a run never exceeds its length
  p_run_bound_r5: assert property (@(posedge clk) disable iff (rst)
    run_q <= RUN_LAST);
endmodule

// File: rtl/pwcap_timebase.sv
module pwcap_timebase #(
  parameter int CNT_W = 16,
  parameter int PRE_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PRE_W-1:0] presc_div,
  input  logic             restart,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] CNT_TOP = {CNT_W{1'b1}};

  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] cnt_q;
  logic             tick;

  assign tick = (pre_q >= presc_div);

  always_ff @(posedge clk) begin
    if (rst || restart || tick) pre_q <= '0;
    else                        pre_q <= pre_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst || restart) cnt_q <= '0;
    else if (tick)      cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = tick && (cnt_q == CNT_TOP) && !restart;

  // R1: without restart the count holds or steps by exactly one
  p_cnt_step_r1: assert property (@(posedge clk) disable iff (rst)
    !$past(restart) |-> ((cnt_q == $past(cnt_q)) ||
                         (cnt_q == CNT_W'($past(cnt_q) + 1'b1))));

  // R2: a restart always leaves the counter at zero
  p_restart_zero_r2: assert property (@(posedge clk) disable iff (rst)
    restart |=> (cnt_q == '0));
endmodule

// File: rtl/pwcap_top.sv
module pwcap_top
  import pwcap_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int PRE_W       = 12,
  parameter int FILT_DIV    = 32,
  parameter int FILT_LEN    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pol_high,
  input  logic [PRE_W-1:0] presc_div,
  input  logic             sig_in,
  output logic [CNT_W-1:0] period_o,
  output logic [CNT_W-1:0] width_o,
  output logic             valid_o,
  output logic             cap_stb_o,
  output logic             ovf_stb_o
);
  logic             sig_sync;
  logic             sig_filt;
  logic             filt_prev_q;
  logic [CNT_W-1:0] cnt;
  logic             wrap;
  pw_event_e        ev;
  logic             lead_edge;
  logic             trail_edge;

  logic [CNT_W-1:0] period_q;
  logic [CNT_W-1:0] width_q;
  logic             valid_q;
  logic             armed_q;
  logic             cap_q;
  logic             ovf_q;

  pwcap_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i (sig_in),
    .q_o (sig_sync)
  );

  pwcap_filter #(.FILT_DIV(FILT_DIV), .FILT_LEN(FILT_LEN)) u_filter (
    .clk (clk),
    .rst (rst),
    .d_i (sig_sync),
    .q_o (sig_filt)
  );

  always_ff @(posedge clk) begin
    if (rst) filt_prev_q <= 1'b0;
    else     filt_prev_q <= sig_filt;
  end

  assign ev         = classify(sig_filt & ~filt_prev_q, ~sig_filt & filt_prev_q, pol_high);
  assign lead_edge  = (ev == EV_LEADING);
  assign trail_edge = (ev == EV_TRAILING);

  pwcap_timebase #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_timebase (
    .clk       (clk),
    .rst       (rst),
    .presc_div (presc_div),
    .restart   (lead_edge),
    .cnt_o     (cnt),
    .wrap_o    (wrap)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      period_q <= '0;
      width_q  <= '0;
      valid_q  <= 1'b0;
      armed_q  <= 1'b0;
      cap_q    <= 1'b0;
      ovf_q    <= 1'b0;
    end else begin
      cap_q <= lead_edge;
      ovf_q <= wrap;
      if (lead_edge) begin
        period_q <= cnt;
        valid_q  <= armed_q && (cnt != '0);
        armed_q  <= 1'b1;
      end else if (wrap) begin
        valid_q  <= 1'b0;
        armed_q  <= 1'b0;
      end
      if (trail_edge) width_q <= cnt;
    end
  end

  assign period_o  = period_q;
  assign width_o   = width_q;
  assign valid_o   = valid_q;
  assign cap_stb_o = cap_q;
  assign ovf_stb_o = ovf_q;

  // R6: capture and rollover are never reported together
  p_cap_ovf_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(cap_q && ovf_q));

  // R7: a rollover leaves the result stale
  p_ovf_clears_r7: assert property (@(posedge clk) disable iff (rst)
    ovf_q |-> !valid_q);

  // R8: a valid capture never carries a zero period
  p_valid_nonzero_r8: assert property (@(posedge clk) disable iff (rst)
    (cap_q && valid_q) |-> (period_q != '0));

  // R2: the period register only moves together with the capture strobe
  p_period_hold_r2: assert property (@(posedge clk) disable iff (rst)
    (period_q != $past(period_q)) |-> cap_q);

  // R2: counter sits at zero in the clock that reports a capture
  p_cap_restart_r2: assert property (@(posedge clk) disable iff (rst)
    cap_q |-> (cnt == '0));

  // R3: the active-time register never moves on a leading-edge capture
  p_width_apart_r3: assert property (@(posedge clk) disable iff (rst)
    (width_q != $past(width_q)) |-> !cap_q);

  // R2: the strobe lasts a single clock
  p_cap_single_r2: assert property (@(posedge clk) disable iff (rst)
    cap_q |=> !cap_q);
endmodule

// File: tb/pwcap_top_tb.sv
`timescale 1ns/1ps
module pwcap_top_tb;
  localparam int TB_CNT_W = 8;
  localparam int TB_PRE_W = 6;
  localparam int TB_FDIV  = 4;
  localparam int TB_FLEN  = 3;

  logic                clk = 1'b0;
  logic                rst = 1'b1;
  logic                pol_high = 1'b1;
  logic [TB_PRE_W-1:0] presc_div = '0;
  logic                sig_in = 1'b0;
  logic [TB_CNT_W-1:0] period_o;
  logic [TB_CNT_W-1:0] width_o;
  logic                valid_o;
  logic                cap_stb_o;
  logic                ovf_stb_o;

  int nvec = 0;
  int nerr = 0;
  int capk = 0;
  int novf = 0;
  int cyc = 0;
  int last_cap_cyc = 0;
  int cur_d = 0;
  int exp_per = 0;
  int exp_wid = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  pwcap_top #(
    .CNT_W(TB_CNT_W), .PRE_W(TB_PRE_W), .FILT_DIV(TB_FDIV), .FILT_LEN(TB_FLEN)
  ) u_dut (
    .clk(clk), .rst(rst), .pol_high(pol_high), .presc_div(presc_div),
    .sig_in(sig_in), .period_o(period_o), .width_o(width_o),
    .valid_o(valid_o), .cap_stb_o(cap_stb_o), .ovf_stb_o(ovf_stb_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nvec++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  // event monitor, sampled one ns after each rising edge
  always @(posedge clk) begin
    #1;
    cyc++;
    if (rst) begin
      capk = 0;
    end else begin
      if (cap_stb_o) begin
        capk++;
        last_cap_cyc = cyc;
        if (capk == 1) begin
          chk(valid_o == 1'b0, "R8 first leading edge not valid", valid_o, 0);
        end else begin
          chk(period_o == exp_per, "R1/R2 period count", period_o, exp_per);
          chk(valid_o == (exp_per != 0), "R8 valid vs non-zero period", valid_o, exp_per != 0);
          chk(width_o == exp_wid, "R3/R4 active-time count", width_o, exp_wid);
        end
      end
      if (ovf_stb_o) begin
        novf++;
        chk(valid_o == 1'b0, "R7 wrap clears valid", valid_o, 0);
        chk(cyc - last_cap_cyc == (1 << TB_CNT_W) * (cur_d + 1),
            "R6 wrap distance from restart", cyc - last_cap_cyc,
            (1 << TB_CNT_W) * (cur_d + 1));
        capk = 0;
      end
    end
  end

  task automatic drive(input logic lvl, input int cycles);
    sig_in = lvl;
    repeat (cycles) @(negedge clk);
  endtask

  task automatic do_reset(input int d, input bit ph);
    @(negedge clk);
    rst = 1'b1;
    pol_high = ph;
    presc_div = TB_PRE_W'(d);
    cur_d = d;
    sig_in = ~ph;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(period_o == 0 && width_o == 0, "R9 reset clears registers", period_o + width_o, 0);
    chk(!valid_o && !cap_stb_o && !ovf_stb_o, "R9 reset clears flags",
        valid_o + cap_stb_o + ovf_stb_o, 0);
    repeat (40) @(negedge clk);
  endtask

  task automatic pulses(input bit ph, input int a, input int i, input int n);
    for (int k = 0; k < n; k++) begin
      drive(ph, a);
      drive(~ph, i);
    end
    repeat (40) @(negedge clk);
  endtask

  task automatic run_train(input int d, input bit ph, input int a, input int i, input int n);
    int ovf0;
    do_reset(d, ph);
    exp_per = (a + i - 1) / (d + 1);
    exp_wid = (a - 1) / (d + 1);
    ovf0 = novf;
    pulses(ph, a, i, n);
    chk(capk == n, "R2/R4 one capture per leading edge", capk, n);
    chk(novf == ovf0, "R6 no wrap from restarts", novf - ovf0, 0);
  endtask

  task automatic run_timeout(input int d);
    int ovf0;
    run_train(d, 1'b1, 12, 20, 3);
    ovf0 = novf;
    drive(1'b0, (3 * (1 << TB_CNT_W) * (d + 1)) / 2);
    chk(novf - ovf0 == 1, "R6 single wrap while idle", novf - ovf0, 1);
    chk(valid_o == 1'b0, "R7 stale after wrap", valid_o, 0);
    pulses(1'b1, 12, 20, 2);
    chk(capk == 2, "R7 re-arm after wrap", capk, 2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nerr++;
      $display("FAIL watchdog (all requirements) actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
      $finish;
    end
  end

  initial begin
    int pre_list [5] = '{0, 1, 2, 3, 7};
    int act_list [3] = '{12, 16, 24};
    int ina_list [3] = '{12, 20, 40};

    // R1 R3 R4 R8: sweep of prescaler, polarity, active and inactive time
    foreach (pre_list[pi])
      for (int ph = 0; ph < 2; ph++)
        foreach (act_list[ai])
          foreach (ina_list[ii])
            run_train(pre_list[pi], ph[0], act_list[ai], ina_list[ii], 4);

    // R8: periods shorter than one prescaled tick are reported invalid
    run_train(31, 1'b1, 12, 12, 3);
    run_train(31, 1'b0, 12, 12, 3);

    // R5: excursions one sample short are rejected, full runs accepted
    do_reset(0, 1'b1);
    drive(1'b1, 8);
    drive(1'b0, 40);
    chk(capk == 0, "R5 short active glitch ignored", capk, 0);
    drive(1'b1, 12);
    drive(1'b0, 40);
    chk(capk == 1, "R5 full-length pulse accepted", capk, 1);
    do_reset(0, 1'b0);
    drive(1'b0, 8);
    drive(1'b1, 40);
    chk(capk == 0, "R5/R4 short low glitch ignored", capk, 0);

    // R6 R7: rollover timeout with two prescaler settings
    run_timeout(0);
    run_timeout(1);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  end
endmodule